// File: doc/BRIEF.md
# Addressable LED Chain Serial Driver

This block sends colour data down a single-wire chain of addressable LEDs, for example two 16x16 panels wired as one 512-pixel string. For each pixel, in index order, it reads a colour word from an external frame memory through a plain address/data read port. It then shifts the word out most significant bit first. Every bit is one high pulse followed by one low pulse, and the two pulse lengths tell a one from a zero.

Every pulse length is a parameter counted in clock cycles. The high and low parts of a zero bit and of a one bit are set separately, so the total bit period can be matched to the chain's timing at any clock rate. With the default values a 50 MHz clock gives bit periods of about 1.25 µs. After the last pixel the line stays low for a latch interval. The block then waits for a start pulse, or begins the next frame on its own when free-running. A mode parameter selects 24-bit colour words or 32-bit colour words with a white channel.

Top module: `ledchain_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `led_o` and `busy_o` are low and `rd_addr_o` is 0.
- R2: When `start_i` is high at a clock edge while idle, `led_o` and `busy_o` both go high in the cycle that follows that edge.
- R3: A one bit drives `led_o` high for T1H cycles and then low for T1L cycles. A zero bit drives it high for T0H cycles and then low for T0L cycles.
- R4: Each pixel word is sent most significant bit first. In 24-bit mode the word is {G[23:16], R[15:8], B[7:0]}.
- R5: Pixels go out in index order 0 to PIX_COUNT-1, with no idle cycle between them. While pixel p is on the line, `rd_addr_o` holds p+1, or 0 for the last pixel. `rd_data_i` is taken as the memory contents one cycle after the address.
- R6: A frame ends after exactly PIX_COUNT pixels, including when PIX_COUNT is a power of two.
- R7: After the final bit, `led_o` stays low for RST_CYC cycles with `busy_o` high. Then `busy_o` falls.
- R8: A start pulse that arrives while `busy_o` is high has no effect.
- R9: With FREE_RUN=1, a new frame begins without `start_i`, one cycle after `busy_o` falls.
- R10: With RGBW=1, each pixel is a 32-bit word {G, R, B, W[7:0]}, sent as 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Requests one frame while idle |
| rd_addr_o | output | PIX_W | Frame memory read address, one pixel ahead |
| rd_data_i | input | 24 or 32 | Colour word read from memory, valid one cycle after the address |
| led_o | output | 1 | Serial line to the LED chain |
| busy_o | output | 1 | High from the first bit until the latch interval ends |

## Verification
The assertions check the following on every cycle:
- the line is quiet when the block is idle;
- every high pulse has one of the two legal widths;
- the line is low during the latch interval;
- the read address stays one pixel ahead of the pixel being sent;
- a frame closes only from the last pixel index;
- the word shifter never loads and shifts in the same cycle.

The exact bit order, the colour word layout, the low pulse widths, the pixel count of a power-of-two chain, the ignored start pulse and the free-running restart are shown only by the bench. Its reference model predicts `busy_o` and `led_o` for every clock and compares them with the design.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2,
        ST_LATCH = 2'd3
    } ledchain_state_e;
endpackage

// File: rtl/ledchain_bit_timing.sv
// Picks the pulse lengths (minus one) for the next high and low phases.
module ledchain_bit_timing #(
    parameter int T0H   = 20,
    parameter int T0L   = 43,
    parameter int T1H   = 40,
    parameter int T1L   = 23,
    parameter int CNT_W = 6
) (
    input  logic             hi_bit_i,
    input  logic             lo_bit_i,
    output logic [CNT_W-1:0] hi_len_o,
    output logic [CNT_W-1:0] lo_len_o
);
    localparam logic [CNT_W-1:0] H0 = CNT_W'(T0H - 1);
    localparam logic [CNT_W-1:0] L0 = CNT_W'(T0L - 1);
    localparam logic [CNT_W-1:0] H1 = CNT_W'(T1H - 1);
    localparam logic [CNT_W-1:0] L1 = CNT_W'(T1L - 1);

    always_comb begin
        hi_len_o = hi_bit_i ? H1 : H0;
        lo_len_o = lo_bit_i ? L1 : L0;
    end
endmodule

// File: rtl/ledchain_word_shift.sv
// Holds the pixel word being sent and counts its bits.
module ledchain_word_shift #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              cur_bit_o,
    output logic              nxt_bit_o,
    output logic              last_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
    } shift_t;

    shift_t shift_d, shift_q;

    always_comb begin
        shift_d = shift_q;
        if (load_i) begin
            shift_d.sh  = din_i;
            shift_d.idx = '0;
        end else if (shift_i) begin
            shift_d.sh  = {shift_q.sh[DATA_W-2:0], 1'b0};
            shift_d.idx = shift_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign cur_bit_o = shift_q.sh[DATA_W-1];
    assign nxt_bit_o = shift_q.sh[DATA_W-2];
    assign last_o    = (shift_q.idx == LAST_IDX);

    assert_ctl_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_i, shift_i}));
    assert_no_shift_past_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !last_o);
endmodule

// File: rtl/ledchain_frame_ctrl.sv
// Frame sequencer: pixel index, read address prefetch, phase timer and line.
module ledchain_frame_ctrl
    import ledchain_pkg::*;
#(
    parameter int PIX_COUNT = 512,
    parameter int PIX_W     = 9,
    parameter int CNT_W     = 12,
    parameter int RST_CYC   = 4000,
    parameter int FREE_RUN  = 0,
    parameter int T0H       = 20,
    parameter int T1H       = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             last_bit_i,
    input  logic [CNT_W-1:0] hi_len_i,
    input  logic [CNT_W-1:0] lo_len_i,
    output logic             hi_sel_load_o,
    output logic             load_o,
    output logic             shift_o,
    output logic [PIX_W-1:0] rd_addr_o,
    output logic             led_o,
    output logic             busy_o
);
    localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(PIX_COUNT - 1);
    localparam logic [CNT_W-1:0] LATCH_LEN = CNT_W'(RST_CYC - 1);

    typedef struct packed {
        ledchain_state_e  state;
        logic [CNT_W-1:0] cnt;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] addr;
        logic             line;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [PIX_W-1:0] addr_next;

    always_comb begin
        addr_next = (ctrl_q.addr == LAST_PIX) ? '0 : ctrl_q.addr + 1'b1;
        // the first bit of a new word sets the next high length
        hi_sel_load_o = (ctrl_q.state == ST_IDLE) || last_bit_i;
        ctrl_d  = ctrl_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i || (FREE_RUN != 0)) begin
                    load_o        = 1'b1;
                    ctrl_d.state  = ST_HIGH;
                    ctrl_d.line   = 1'b1;
                    ctrl_d.cnt    = hi_len_i;
                    ctrl_d.pix    = '0;
                    ctrl_d.addr   = addr_next;
                end
            end
            ST_HIGH: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.state = ST_LOW;
                    ctrl_d.line  = 1'b0;
                    ctrl_d.cnt   = lo_len_i;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (ctrl_q.cnt != '0) begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end else if (!last_bit_i) begin
                    shift_o      = 1'b1;
                    ctrl_d.state = ST_HIGH;
                    ctrl_d.line  = 1'b1;
                    ctrl_d.cnt   = hi_len_i;
                end else if (ctrl_q.pix != LAST_PIX) begin
                    // compare against count-1: safe for power-of-two chains
                    load_o       = 1'b1;
                    ctrl_d.state = ST_HIGH;
                    ctrl_d.line  = 1'b1;
                    ctrl_d.cnt   = hi_len_i;
                    ctrl_d.pix   = ctrl_q.pix + 1'b1;
                    ctrl_d.addr  = addr_next;
                end else begin
                    ctrl_d.state = ST_LATCH;
                    ctrl_d.cnt   = LATCH_LEN;
                    ctrl_d.pix   = '0;
                end
            end
            default: begin
                if (ctrl_q.cnt == '0) ctrl_d.state = ST_IDLE;
                else                  ctrl_d.cnt   = ctrl_q.cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign rd_addr_o = ctrl_q.addr;
    assign led_o     = ctrl_q.line;
    assign busy_o    = (ctrl_q.state != ST_IDLE);

    // length of the current high run, for the pulse width check
    logic [CNT_W:0] hi_run_q;
    localparam logic [CNT_W:0] RUN0 = (CNT_W+1)'(T0H);
    localparam logic [CNT_W:0] RUN1 = (CNT_W+1)'(T1H);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_run_q <= '0;
        else if (led_o) hi_run_q <= hi_run_q + 1'b1;
        else            hi_run_q <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!led_o && rd_addr_o == '0));
    assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_o) |-> (hi_run_q == RUN0 || hi_run_q == RUN1));
    assert_prefetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_HIGH || ctrl_q.state == ST_LOW) |->
        rd_addr_o == ((ctrl_q.pix == LAST_PIX) ? '0 : ctrl_q.pix + 1'b1));
    assert_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.state == ST_LATCH) |-> $past(ctrl_q.pix) == LAST_PIX);
    assert_latch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_LATCH) |-> (!led_o && busy_o));
endmodule

// File: rtl/ledchain_tx.sv
module ledchain_tx #(
    parameter int PIX_COUNT = 512,
    parameter int RGBW      = 0,
    parameter int T0H       = 20,
    parameter int T0L       = 43,
    parameter int T1H       = 40,
    parameter int T1L       = 23,
    parameter int RST_CYC   = 4000,
    parameter int FREE_RUN  = 0,
    localparam int DATA_W   = (RGBW != 0) ? 32 : 24,
    localparam int PIX_W    = (PIX_COUNT > 1) ? $clog2(PIX_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [PIX_W-1:0]  rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              led_o,
    output logic              busy_o
);
    localparam int MAX_A = (T0H > T0L) ? T0H : T0L;
    localparam int MAX_B = (T1H > T1L) ? T1H : T1L;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_D = (MAX_C > RST_CYC) ? MAX_C : RST_CYC;
    localparam int CNT_W = $clog2(MAX_D + 1);

    logic             cur_bit, nxt_bit, last_bit;
    logic             hi_sel_load, load, shift, hi_bit;
    logic [CNT_W-1:0] hi_len, lo_len;

    assign hi_bit = hi_sel_load ? rd_data_i[DATA_W-1] : nxt_bit;

    ledchain_word_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .shift_i   (shift),
        .din_i     (rd_data_i),
        .cur_bit_o (cur_bit),
        .nxt_bit_o (nxt_bit),
        .last_o    (last_bit)
    );

    ledchain_bit_timing #(
        .T0H(T0H), .T0L(T0L), .T1H(T1H), .T1L(T1L), .CNT_W(CNT_W)
    ) u_timing (
        .hi_bit_i (hi_bit),
        .lo_bit_i (cur_bit),
        .hi_len_o (hi_len),
        .lo_len_o (lo_len)
    );

    ledchain_frame_ctrl #(
        .PIX_COUNT (PIX_COUNT),
        .PIX_W     (PIX_W),
        .CNT_W     (CNT_W),
        .RST_CYC   (RST_CYC),
        .FREE_RUN  (FREE_RUN),
        .T0H       (T0H),
        .T1H       (T1H)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .last_bit_i    (last_bit),
        .hi_len_i      (hi_len),
        .lo_len_i      (lo_len),
        .hi_sel_load_o (hi_sel_load),
        .load_o        (load),
        .shift_o       (shift),
        .rd_addr_o     (rd_addr_o),
        .led_o         (led_o),
        .busy_o        (busy_o)
    );
endmodule

// File: tb/ledchain_tx_bench.sv
module ledchain_tx_bench;
    // instance A: start-triggered, 24-bit words, power-of-two chain
    localparam int A_PIX = 4,  A_BITS = 24;
    localparam int A_T0H = 2,  A_T0L = 5, A_T1H = 5, A_T1L = 2, A_RST = 12;
    // instance B: free-running, 32-bit words
    localparam int B_PIX = 2,  B_BITS = 32;
    localparam int B_T0H = 1,  B_T0L = 3, B_T1H = 3, B_T1L = 1, B_RST = 5;
    localparam int B_SEED = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int seed_a = 5;
    string tag_a = "R1";
    bit b_sync = 1'b0;
    int qa[$];
    int qb[$];

    function automatic logic [31:0] mem_word(int seed, int addr);
        logic [31:0] x;
        if (seed == 0) return 32'h0;
        if (seed == 1) return 32'hFFFF_FFFF;
        x = (32'(seed) * 32'h9E37_79B1) ^ (32'(addr + 1) * 32'h85EB_CA6B);
        x = x ^ (x >> 15);
        return x;
    endfunction

    // DUT A with its memory (registered read, one cycle latency)
    logic [1:0]  rd_addr_a;
    logic [23:0] rd_data_a;
    logic [31:0] word_a;
    logic        led_a, busy_a;
    assign word_a = mem_word(seed_a, int'(rd_addr_a));
    always @(posedge clk) rd_data_a <= word_a[23:0];

    ledchain_tx #(
        .PIX_COUNT(A_PIX), .RGBW(0), .T0H(A_T0H), .T0L(A_T0L),
        .T1H(A_T1H), .T1L(A_T1L), .RST_CYC(A_RST), .FREE_RUN(0)
    ) u_ledchain_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .rd_addr_o(rd_addr_a),
        .rd_data_i(rd_data_a), .led_o(led_a), .busy_o(busy_a)
    );

    // DUT B
    logic        rd_addr_b;
    logic [31:0] rd_data_b;
    logic [31:0] word_b;
    logic        led_b, busy_b;
    assign word_b = mem_word(B_SEED, int'(rd_addr_b));
    always @(posedge clk) rd_data_b <= word_b;

    ledchain_tx #(
        .PIX_COUNT(B_PIX), .RGBW(1), .T0H(B_T0H), .T0L(B_T0L),
        .T1H(B_T1H), .T1L(B_T1L), .RST_CYC(B_RST), .FREE_RUN(1)
    ) u_ledchain_tx_w (
        .clk(clk), .rst_n(rst_n), .start_i(1'b0), .rd_addr_o(rd_addr_b),
        .rd_data_i(rd_data_b), .led_o(led_b), .busy_o(busy_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_v(input bit sel, input int v);
        if (sel) qb.push_back(v);
        else     qa.push_back(v);
    endtask

    // expected {busy,led} per cycle for one frame plus latch (and idle gap)
    task automatic push_frame(input bit sel, input int npix, input int nbits,
                              input int seed, input int t0h, input int t0l,
                              input int t1h, input int t1l, input int rst,
                              input bit tail_idle);
        for (int p = 0; p < npix; p++) begin
            logic [31:0] w;
            w = mem_word(seed, p);
            for (int b = nbits - 1; b >= 0; b--) begin
                int h, l;
                h = w[b] ? t1h : t0h;
                l = w[b] ? t1l : t0l;
                for (int i = 0; i < h; i++) push_v(sel, 3);
                for (int i = 0; i < l; i++) push_v(sel, 2);
            end
        end
        for (int i = 0; i < rst; i++) push_v(sel, 2);
        if (tail_idle) push_v(sel, 0);
    endtask

    // per-clock comparison, instance A
    always @(negedge clk) begin
        if (rst_n) begin
            int e, act;
            act = {30'd0, busy_a, led_a};
            if (qa.size() != 0) begin
                e = qa.pop_front();
                chk(act == e, tag_a, act, e);
            end else begin
                chk(act == 0, "R1 idle line", act, 0);
                chk(rd_addr_a == 2'd0, "R1 idle address", int'(rd_addr_a), 0);
            end
        end
    end

    // per-clock comparison, instance B (R9 free run, R10 32-bit words)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!b_sync && busy_b) b_sync = 1'b1;
            if (b_sync) begin
                int e, act;
                if (qb.size() == 0)
                    push_frame(1'b1, B_PIX, B_BITS, B_SEED, B_T0H, B_T0L,
                               B_T1H, B_T1L, B_RST, 1'b1);
                e = qb.pop_front();
                act = {30'd0, busy_b, led_b};
                chk(act == e, "R9 R10 free-run stream", act, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic run_frame(input int seed, input string tag, input bit repulse);
        seed_a = seed;
        tick();
        tick();
        tag_a = tag;
        start_a = 1'b1;
        push_frame(1'b0, A_PIX, A_BITS, seed, A_T0H, A_T0L, A_T1H, A_T1L, A_RST, 1'b0);
        tick();
        start_a = 1'b0;
        if (repulse) begin
            // R8: start while busy must leave the stream untouched
            repeat (100) tick();
            start_a = 1'b1;
            tick();
            start_a = 1'b0;
            repeat (300) tick();
            start_a = 1'b1;
            tick();
            start_a = 1'b0;
        end
        while (qa.size() != 0) tick();
        repeat (4) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_a == 1'b0, "R1 reset busy", int'(busy_a), 0);
        chk(led_a == 1'b0, "R1 reset line", int'(led_a), 0);
        chk(rd_addr_a == 2'd0, "R1 reset address", int'(rd_addr_a), 0);
        chk(busy_b == 1'b0, "R1 reset busy B", int'(busy_b), 0);
        #1 rst_n = 1'b1;
        repeat (5) tick();
        run_frame(7,  "R2 R4 R5 R6 R7 mixed data", 1'b0);
        run_frame(0,  "R3 zero bits", 1'b0);
        run_frame(1,  "R3 one bits", 1'b0);
        run_frame(23, "R8 start during frame ignored", 1'b0 | 1'b1);
        run_frame(42, "R5 R6 power-of-two chain again", 1'b0);
        repeat (600) tick();
        chk(b_sync, "R9 free-run frame started", int'(b_sync), 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule